// File: doc/BRIEF.md
# Power-Down and Wake-Up Sequencer

This block takes a small microcontroller system into a low-power state and back out. Software sets a power-down request bit in a control register. The block does not act on it at once: it waits a fixed number of CPU clock cycles, so the program has time to halt the core. Only after that wait does it raise the global power-down signal. That signal turns off every switchable function and the high-speed clock source. The low-frequency oscillator keeps running.

Each switchable function has a shutdown output. That output is the OR of the global power-down signal and the function's own disable bit. Asynchronous wake lines are synchronized and held in the always-on low-frequency clock domain. When any of them fires during power down, the global signal drops at once and the CPU clock restarts. The CPU domain then counts a fixed settle window and raises the wake interrupt on the core's interrupt-0 line.

A wake that arrives during the entry wait cancels the power-down. The request bit clears itself whenever a wake is accepted. A routing bit chooses what drives the interrupt-0 output: the wake interrupt, or the ordinary interrupt-0 source.

Top module: `pwr_seq`

## Requirements
- R1: After reset, `pd_sig_o` is 0, `fn_off_o` is all zeros, `lf_off_o` is 0, `int0_o` equals `int0_src_i`, and both registers read 0.
- R2: The control register is at address 0. Bit 0 is the power-down request and bit 1 is the wake-routing bit. A write followed by a read returns both bits.
- R3: `pd_sig_o` rises exactly ENTRY_CYC rising CPU clock edges after the edge that writes the request bit as 1. It stays 0 through the edges before that.
- R4: Each bit f of `fn_off_o` equals bit f of the disable register (address 1), ORed with `pd_sig_o`. The bit order is: 0 analog/PLL, 1 USB transceiver suspend, 2 comparator, 3 high-speed oscillator, 4 smart-card power, 5 flash read one-shot.
- R5: `lf_off_o` follows only bit 6 of the disable register. The power-down signal never sets it.
- R6: A wake line held high during the entry wait cancels the power-down. `pd_sig_o` then never rises, and the request bit reads 0 afterwards.
- R7: While powered down, the CPU clock is stopped. A high level on any wake line drops `pd_sig_o`, and `fn_off_o` returns to the disable-register value.
- R8: When the routing bit is set, `int0_o` rises on exactly the (SETTLE_CYC+3)-th rising CPU clock edge after the clock restarts. It stays high until a pulse on `irq_ack_i`.
- R9: An accepted wake from power down clears the request bit, and the block returns to normal running.
- R10: When the routing bit is clear, a wake still restores power, but no wake interrupt is raised. `int0_o` follows `int0_src_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock; stopped externally while `pd_sig_o` is high |
| clk_lf_i | input | 1 | Always-on low-frequency clock |
| rst_i | input | 1 | Synchronous reset, active high, for both domains |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 disable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| wake_i | input | NUM_WAKE | Asynchronous wake request lines, active high |
| int0_src_i | input | 1 | Ordinary interrupt-0 source, used when routing is clear |
| irq_ack_i | input | 1 | Clears a pending wake interrupt |
| pd_sig_o | output | 1 | Global power-down signal |
| fn_off_o | output | 6 | Per-function shutdown outputs |
| lf_off_o | output | 1 | Low-frequency oscillator shutdown |
| int0_o | output | 1 | Interrupt-0 line to the core |

## Verification
The bench uses the default parameters: an entry wait of 32 cycles, a settle window of 512 cycles, eight wake lines and two-stage synchronizers. At these sizes both windows are cheap enough to count edge by edge, so the exact cycle of `pd_sig_o` and of `int0_o` is checked rather than a range. The bench's clock model stops the CPU clock whenever `pd_sig_o` is high. This exercises the restart path through frozen synchronizers. Random wake-line indices, disable patterns and abort points cover every wake input and many entry-window positions.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_ENTRY   = 3'd1,
    ST_DOWN    = 3'd2,
    ST_RESTART = 3'd3,
    ST_SETTLE  = 3'd4
  } seq_state_t;

  // switchable functions, index = fn_off bit
  localparam int FN_ANALOG = 0;
  localparam int FN_USB    = 1;
  localparam int FN_CMP    = 2;
  localparam int FN_HOSC   = 3;
  localparam int FN_CARD   = 4;
  localparam int FN_FLASH  = 5;
  localparam int FN_NUM    = 6;

  // disable register: function bits, then the low-frequency oscillator
  localparam int DIS_LF_BIT = FN_NUM;
  localparam int DIS_W      = FN_NUM + 1;

  // control register bits
  localparam int CTRL_PDN_BIT   = 0;
  localparam int CTRL_ROUTE_BIT = 1;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DIS  = 1'b1;

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
  import pwr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             pdn_clr_i,
  output logic [7:0]       rdata_o,
  output logic             pdn_o,
  output logic             route_o,
  output logic [DIS_W-1:0] dis_o
);

  logic             pdn_q;
  logic             route_q;
  logic [DIS_W-1:0] dis_q;
  logic             unused_wbit;

  assign unused_wbit = wdata_i[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      pdn_q   <= 1'b0;
      route_q <= 1'b0;
      dis_q   <= '0;
    end else begin
      if (we_i && addr_i == ADDR_CTRL) begin
        pdn_q   <= wdata_i[CTRL_PDN_BIT];
        route_q <= wdata_i[CTRL_ROUTE_BIT];
      end
      if (we_i && addr_i == ADDR_DIS) begin
        dis_q <= wdata_i[DIS_W-1:0];
      end
      // an accepted wake wins over a same-cycle write
      if (pdn_clr_i) begin
        pdn_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) begin
      rdata_o[CTRL_PDN_BIT]   = pdn_q;
      rdata_o[CTRL_ROUTE_BIT] = route_q;
    end else begin
      rdata_o[DIS_W-1:0] = dis_q;
    end
  end

  assign pdn_o   = pdn_q;
  assign route_o = route_q;
  assign dis_o   = dis_q;

  // R9
  pdn_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pdn_q) |-> $past(pdn_clr_i || we_i));

endmodule

// File: rtl/pwr_seq_wake_lf.sv
module pwr_seq_wake_lf #(
  parameter int NUM_WAKE    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_lf,
  input  logic                rst,
  input  logic [NUM_WAKE-1:0] wake_i,
  input  logic                pd_main_i,
  output logic                wake_lf_o
);

  logic [NUM_WAKE-1:0] wake_s;
  logic                pd_s;
  logic                any_wake;
  logic                wake_q;

  pwr_seq_sync #(.W(NUM_WAKE), .STAGES(SYNC_STAGES)) u_wake_sync (
    .clk (clk_lf),
    .rst (rst),
    .d   (wake_i),
    .q   (wake_s)
  );

  pwr_seq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pd_sync (
    .clk (clk_lf),
    .rst (rst),
    .d   (pd_main_i),
    .q   (pd_s)
  );

  assign any_wake = |wake_s;

  // set on a wake while down; released once the CPU domain drops its request
  always_ff @(posedge clk_lf) begin
    if (rst) begin
      wake_q <= 1'b0;
    end else if (!pd_s) begin
      wake_q <= 1'b0;
    end else if (any_wake) begin
      wake_q <= 1'b1;
    end
  end

  assign wake_lf_o = wake_q;

  // R7
  wake_set_chk: assert property (@(posedge clk_lf) disable iff (rst)
    $rose(wake_q) |-> $past(pd_s && any_wake));

  // R9
  wake_release_chk: assert property (@(posedge clk_lf) disable iff (rst)
    (wake_q && !pd_s) |=> !wake_q);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int NUM_WAKE    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 32,
  parameter int SETTLE_CYC  = 512
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pdn_i,
  input  logic                route_i,
  input  logic [NUM_WAKE-1:0] wake_i,
  input  logic                wake_lf_i,
  input  logic                ack_i,
  output logic                pd_req_o,
  output logic                pdn_clr_o,
  output logic                irq_o
);

  localparam int CNT_MAX = (ENTRY_CYC > SETTLE_CYC) ? ENTRY_CYC : SETTLE_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] ENTRY_LAST  = CW'(ENTRY_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

  seq_state_t    state_q;
  logic [CW-1:0] cnt_q;
  logic          pd_q;
  logic          irq_q;
  logic [NUM_WAKE-1:0] wake_m_bits;
  logic          wake_m;
  logic          wake_lf_m;

  pwr_seq_sync #(.W(NUM_WAKE), .STAGES(SYNC_STAGES)) u_wake_sync (
    .clk (clk),
    .rst (rst),
    .d   (wake_i),
    .q   (wake_m_bits)
  );

  pwr_seq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_lf_sync (
    .clk (clk),
    .rst (rst),
    .d   (wake_lf_i),
    .q   (wake_lf_m)
  );

  assign wake_m = |wake_m_bits;

  // the request bit clears in the same edge the wake is taken
  assign pdn_clr_o = (state_q == ST_ENTRY && wake_m) ||
                     (state_q == ST_DOWN  && wake_lf_m);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      pd_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (ack_i) begin
        irq_q <= 1'b0;
      end
      unique case (state_q)
        ST_RUN: begin
          if (pdn_i) begin
            state_q <= ST_ENTRY;
            cnt_q   <= CW'(1);
          end
        end
        ST_ENTRY: begin
          if (wake_m) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end else if (cnt_q == ENTRY_LAST) begin
            state_q <= ST_DOWN;
            pd_q    <= 1'b1;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_DOWN: begin
          if (wake_lf_m) begin
            state_q <= ST_RESTART;
            pd_q    <= 1'b0;
          end
        end
        ST_RESTART: begin
          state_q <= ST_SETTLE;
          cnt_q   <= CW'(1);
        end
        ST_SETTLE: begin
          if (cnt_q == SETTLE_LAST) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            if (route_i) begin
              irq_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
          pd_q    <= 1'b0;
        end
      endcase
    end
  end

  assign pd_req_o = pd_q;
  assign irq_o    = irq_q;

  // R3
  pd_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_q) |-> $past(state_q == ST_ENTRY && cnt_q == ENTRY_LAST && !wake_m));

  // R6
  entry_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ENTRY && wake_m) |=> (state_q == ST_RUN && !pd_q));

  // R7
  wake_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DOWN && wake_lf_m) |=> (!pd_q && state_q == ST_RESTART));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(state_q == ST_SETTLE && route_i));

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETTLE) |-> (cnt_q <= SETTLE_LAST));

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int NUM_WAKE    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 32,
  parameter int SETTLE_CYC  = 512
) (
  input  logic                clk_i,
  input  logic                clk_lf_i,
  input  logic                rst_i,
  input  logic                reg_we_i,
  input  logic                reg_addr_i,
  input  logic [7:0]          reg_wdata_i,
  output logic [7:0]          reg_rdata_o,
  input  logic [NUM_WAKE-1:0] wake_i,
  input  logic                int0_src_i,
  input  logic                irq_ack_i,
  output logic                pd_sig_o,
  output logic [FN_NUM-1:0]   fn_off_o,
  output logic                lf_off_o,
  output logic                int0_o
);

  logic             pdn;
  logic             route;
  logic [DIS_W-1:0] dis;
  logic             pdn_clr;
  logic             pd_req;
  logic             wake_lf;
  logic             wake_irq;
  logic             pd_sig;

  pwr_seq_regs u_regs (
    .clk       (clk_i),
    .rst       (rst_i),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .pdn_clr_i (pdn_clr),
    .rdata_o   (reg_rdata_o),
    .pdn_o     (pdn),
    .route_o   (route),
    .dis_o     (dis)
  );

  pwr_seq_fsm #(
    .NUM_WAKE    (NUM_WAKE),
    .SYNC_STAGES (SYNC_STAGES),
    .ENTRY_CYC   (ENTRY_CYC),
    .SETTLE_CYC  (SETTLE_CYC)
  ) u_fsm (
    .clk       (clk_i),
    .rst       (rst_i),
    .pdn_i     (pdn),
    .route_i   (route),
    .wake_i    (wake_i),
    .wake_lf_i (wake_lf),
    .ack_i     (irq_ack_i),
    .pd_req_o  (pd_req),
    .pdn_clr_o (pdn_clr),
    .irq_o     (wake_irq)
  );

  pwr_seq_wake_lf #(
    .NUM_WAKE    (NUM_WAKE),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_wake_lf (
    .clk_lf    (clk_lf_i),
    .rst       (rst_i),
    .wake_i    (wake_i),
    .pd_main_i (pd_req),
    .wake_lf_o (wake_lf)
  );

  // a held wake releases power without waiting for the stopped CPU clock
  assign pd_sig   = pd_req & ~wake_lf;
  assign pd_sig_o = pd_sig;

  for (genvar f = 0; f < FN_NUM; f++) begin : g_fn_off
    assign fn_off_o[f] = dis[f] | pd_sig;
  end

  assign lf_off_o = dis[DIS_LF_BIT];
  assign int0_o   = route ? wake_irq : int0_src_i;

endmodule

// File: tb/pwr_seq_tb.sv
`timescale 1ns/1ps
module pwr_seq_tb;

  localparam int NW     = 8;
  localparam int ENTRY  = 32;
  localparam int SETTLE = 512;

  logic          clk = 1'b0;
  logic          clk_lf = 1'b0;
  logic          rst = 1'b1;
  logic          we = 1'b0;
  logic          addr = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [NW-1:0] wake = '0;
  logic          int0_src = 1'b0;
  logic          ack = 1'b0;
  logic          pd_sig;
  logic [5:0]    fn_off;
  logic          lf_off;
  logic          int0;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  logic [6:0] cur_dis = '0;

  pwr_seq #(.NUM_WAKE(NW), .ENTRY_CYC(ENTRY), .SETTLE_CYC(SETTLE)) u_dut (
    .clk_i       (clk),
    .clk_lf_i    (clk_lf),
    .rst_i       (rst),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .wake_i      (wake),
    .int0_src_i  (int0_src),
    .irq_ack_i   (ack),
    .pd_sig_o    (pd_sig),
    .fn_off_o    (fn_off),
    .lf_off_o    (lf_off),
    .int0_o      (int0)
  );

  // 200 MHz CPU clock, parked low while power-down is active
  always begin
    #2.5;
    if (clk || !pd_sig) clk = ~clk;
  end
  always #20 clk_lf = ~clk_lf;
  always @(posedge clk) edges++;

  function automatic logic [5:0] exp_fn(logic [6:0] d, logic pd);
    return d[5:0] | {6{pd}};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a; #1;
    d = rdata;
  endtask

  // request power down with the routing bit given, then check the entry timing (R3)
  task automatic enter_down(input logic rt);
    logic early;
    early = 1'b0;
    wr(1'b0, {6'd0, rt, 1'b1});
    for (int i = 1; i < ENTRY; i++) begin
      @(posedge clk); #1;
      if (pd_sig) early = 1'b1;
    end
    chk(!early, "R3 early", int'(early), 0);
    @(posedge clk); #1;
    chk(pd_sig, "R3 assert", int'(pd_sig), 1);
  endtask

  // while down: clock parked, functions off, lf follows its own bit (R4 R5 R7)
  task automatic check_down();
    int e0;
    e0 = edges;
    #300;
    chk(edges == e0, "R7 clock stopped", edges - e0, 0);
    chk(fn_off == exp_fn(cur_dis, 1'b1), "R4 down", int'(fn_off), int'(exp_fn(cur_dis, 1'b1)));
    chk(lf_off == cur_dis[6], "R5 down", int'(lf_off), int'(cur_dis[6]));
  endtask

  task automatic wake_up(input int idx, input logic rt);
    int n;
    logic [7:0] r;
    wake[idx] = 1'b1;
    wait (!pd_sig);
    wake = '0;
    n = 0;
    if (rt) begin
      do begin
        @(posedge clk); #1;
        n++;
      end while (!int0 && n < 2000);
      chk(n == SETTLE + 3, "R8 settle", n, SETTLE + 3);
      chk(fn_off == exp_fn(cur_dis, 1'b0), "R7 restore", int'(fn_off), int'(exp_fn(cur_dis, 1'b0)));
      repeat (20) @(posedge clk);
      #1;
      chk(int0, "R8 held", int'(int0), 1);
      rd(1'b0, r);
      chk(r[1:0] == 2'b10, "R9 pdn cleared", int'(r[1:0]), 2);
      @(negedge clk); ack = 1'b1;
      @(posedge clk); #1; ack = 1'b0;
      chk(!int0, "R8 ack", int'(int0), 0);
    end else begin
      repeat (SETTLE + 20) @(posedge clk);
      #1;
      chk(!int0, "R10 no irq", int'(int0), 0);
      @(negedge clk); int0_src = 1'b1; #1;
      chk(int0, "R10 follow", int'(int0), 1);
      @(negedge clk); int0_src = 1'b0; #1;
      chk(!int0, "R10 follow low", int'(int0), 0);
      rd(1'b0, r);
      chk(r[1:0] == 2'b00, "R9 pdn cleared", int'(r[1:0]), 0);
    end
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5EED));
    #400;
    @(negedge clk); rst = 1'b0;
    #1;
    // R1
    chk(!pd_sig && fn_off == 6'd0 && !lf_off, "R1 outputs", int'({pd_sig, lf_off, fn_off}), 0);
    chk(int0 == int0_src, "R1 int0", int'(int0), int'(int0_src));
    rd(1'b0, r); chk(r == 8'd0, "R1 ctrl", int'(r), 0);
    rd(1'b1, r); chk(r == 8'd0, "R1 dis", int'(r), 0);

    // R2
    wr(1'b0, 8'b0000_0010);
    rd(1'b0, r); chk(r == 8'h02, "R2 ctrl rw", int'(r), 2);

    // R4 R5 random disable patterns
    for (int i = 0; i < 8; i++) begin
      cur_dis = 7'($urandom);
      wr(1'b1, {1'b0, cur_dis});
      #1;
      chk(fn_off == exp_fn(cur_dis, 1'b0), "R4 dis", int'(fn_off), int'(exp_fn(cur_dis, 1'b0)));
      chk(lf_off == cur_dis[6], "R5 lf", int'(lf_off), int'(cur_dis[6]));
    end
    cur_dis = 7'h40;
    wr(1'b1, {1'b0, cur_dis});

    // directed full cycle, lowest and highest wake lines
    enter_down(1'b1); check_down(); wake_up(0, 1'b1);
    enter_down(1'b1); check_down(); wake_up(NW - 1, 1'b1);

    // R6 entry aborts at random points
    for (int i = 0; i < 5; i++) begin
      int k;
      logic seen;
      k = 1 + int'($urandom_range(0, 19));
      seen = 1'b0;
      wr(1'b0, 8'b0000_0011);
      repeat (k) @(posedge clk);
      @(negedge clk); wake[$urandom_range(0, NW - 1)] = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk); wake = '0;
      repeat (ENTRY + 10) begin
        @(posedge clk); #1;
        if (pd_sig) seen = 1'b1;
      end
      chk(!seen, "R6 abort", int'(seen), 0);
      rd(1'b0, r); chk(r[0] == 1'b0, "R6 pdn cleared", int'(r[0]), 0);
    end

    // routing clear
    enter_down(1'b0); check_down(); wake_up(3, 1'b0);

    // random full cycles
    for (int i = 0; i < 4; i++) begin
      cur_dis = 7'($urandom);
      wr(1'b1, {1'b0, cur_dis});
      enter_down(1'b1); check_down();
      wake_up(int'($urandom_range(0, NW - 1)), 1'b1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule